// File: doc/BRIEF.md
# Walsh spectral bit-stream regenerator

This block takes in a serial test stream of N bits that belongs to one circuit input, where N is a power of two. It produces a new stream of the same length that keeps the dominant parts of the original stream's Walsh spectrum. The block first maps each bit to a value of +1 or -1. It then computes the N Walsh coefficients with an in-place fast Walsh-Hadamard butterfly. Each coefficient is weighed against a fixed power limit: a strong coefficient is kept as it is, and a weak one is replaced by a small pseudo-random value. A second pass through the same butterfly turns the modified spectrum back into time samples, and the sign of each sample gives the output bit.

A generator of test vectors uses the block by loading a seed and pulsing `start`. It then streams the N bits in and collects the N regenerated bits. Changing the seed gives another stream with the same dominant spectral content. The input and output streams use valid/ready handshakes. A bit moves only in a cycle where both valid and ready are high. The block holds `in_ready` high only while it is capturing. The consumer may hold `out_ready` low for any number of cycles, and the offered bit then waits unchanged. `start` and `done` are plain control pins.

Top module: `walsh_regen`

## Requirements
- R1: While idle, `in_ready` is low. A `start` accepted in idle raises `in_ready`. The block then captures exactly N bits, one on each cycle with `in_valid` and `in_ready` both high, and maps logic 1 to +1 and logic 0 to -1. After the N-th bit `in_ready` drops, and further `in_valid` activity has no effect on the output.
- R2: The forward transform gives coefficient k = sum over n of x[n]·(-1)^popcount(k AND n). This is natural Sylvester ordering: row 1 alternates sign on every sample, and row 2 repeats +,+,-,-.
- R3: With unnormalized coefficients c, a coefficient is essential when c·c > N, which is a normalized power above 1/128 for N = 128. An essential coefficient reaches the inverse transform unchanged.
- R4: A noise coefficient (c·c ≤ N) at index k is replaced by the value taken from the perturbation state S_k. The magnitude is S_k[M-1:0] with M = log2(N)/2 rounded down, and the value is negative when S_k[15] is 1.
- R5: On an accepted `start`, S_0 is loaded from `seed`, and a seed of zero loads 1 instead. S_{k+1} = {S_k[14:0], S_k[15]^S_k[13]^S_k[12]^S_k[10]}, so the register advances once per coefficient index, whether or not that coefficient is replaced.
- R6: The inverse transform applies the same matrix to the modified coefficients. Output bit n is 1 when sample n is positive and 0 when it is negative.
- R7: A regenerated sample of exactly zero gives output bit 1.
- R8: Output bits leave in time order n = 0..N-1, one per handshake. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the N-th output bit, and `out_valid` is low in that cycle.
- R10: A `start` that arrives while a stream is being captured, transformed or emitted is ignored, and the stream being processed is not affected.
- R11: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new stream when idle |
| seed | input | 16 | Perturbation seed, loaded on start |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block accepts an input bit |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Regenerated bit is offered |
| out_ready | input | 1 | Consumer accepts the output bit |
| out_bit | output | 1 | Serial regenerated bit |
| done | output | 1 | One-cycle pulse after the last output bit |

## Verification
The case that is hardest to reach from the ports is a regenerated sample that lands exactly on zero (R7). It needs the kept coefficients and the perturbed ones to cancel at one time index, and the perturbation values depend on the seed in a way that is hard to predict. The bench runs its own spectral model over many seeds for a fixed pseudo-random input. It picks a seed that gives at least one zero sample and then runs that stream through the block. Other streams cover back-pressure, input gaps, idle-time input noise, `start` pulses while busy, and a zero seed.

// File: rtl/whr_pkg.sv
package whr_pkg;
  localparam int SEED_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FWD,
    ST_CLASS,
    ST_INV,
    ST_EMIT,
    ST_DONE
  } whr_state_e;

  // Fibonacci step of x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [SEED_W-1:0] lfsr_step(input logic [SEED_W-1:0] s);
    return {s[SEED_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/whr_lfsr.sv
module whr_lfsr #(
  parameter int MAG_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [whr_pkg::SEED_W-1:0] seed,
  input  logic                       advance,
  output logic                       pert_neg,
  output logic [MAG_W-1:0]           pert_mag
);
  logic [whr_pkg::SEED_W-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= whr_pkg::SEED_W'(1);
    else if (load)    state <= (seed == '0) ? whr_pkg::SEED_W'(1) : seed;
    else if (advance) state <= whr_pkg::lfsr_step(state);
  end

  assign pert_neg = state[whr_pkg::SEED_W-1];
  assign pert_mag = state[MAG_W-1:0];
endmodule

// File: rtl/whr_butterfly.sv
module whr_butterfly #(
  parameter int LOG2N = 7,
  parameter int ACC_W = 16,
  parameter int PW    = 3
) (
  input  logic [PW-1:0]           pass,
  input  logic [LOG2N-2:0]        pair,
  input  logic signed [ACC_W-1:0] a,
  input  logic signed [ACC_W-1:0] b,
  output logic [LOG2N-1:0]        idx_lo,
  output logic [LOG2N-1:0]        idx_hi,
  output logic signed [ACC_W-1:0] sum,
  output logic signed [ACC_W-1:0] diff
);
  logic [LOG2N-1:0] span;
  logic [LOG2N-1:0] mask;
  logic [LOG2N-1:0] p_ext;

  always_comb begin
    span   = LOG2N'(1) << pass;
    mask   = span - LOG2N'(1);
    p_ext  = {1'b0, pair};
    // open a zero bit at position 'pass' in the pair index
    idx_lo = ((p_ext & ~mask) << 1) | (p_ext & mask);
    idx_hi = idx_lo | span;
    sum    = a + b;
    diff   = a - b;
  end
endmodule

// File: rtl/whr_classify.sv
module whr_classify #(
  parameter int N     = 128,
  parameter int ACC_W = 16,
  parameter int MAG_W = 3
) (
  input  logic signed [ACC_W-1:0] coef,
  input  logic                    pert_neg,
  input  logic [MAG_W-1:0]        pert_mag,
  output logic signed [ACC_W-1:0] coef_out
);
  localparam int SQ_W = 2 * ACC_W;

  logic [ACC_W-1:0]        mag;
  logic [SQ_W-1:0]         sq;
  logic                    keep;
  logic signed [ACC_W-1:0] pmag;

  always_comb begin
    mag      = coef[ACC_W-1] ? ACC_W'(-coef) : ACC_W'(coef);
    sq       = {{ACC_W{1'b0}}, mag} * {{ACC_W{1'b0}}, mag};
    keep     = sq > SQ_W'(N);
    pmag     = {{(ACC_W-MAG_W){1'b0}}, pert_mag};
    coef_out = keep ? coef : (pert_neg ? -pmag : pmag);
  end
endmodule

// File: rtl/walsh_regen.sv
module walsh_regen #(
  parameter int LOG2N = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [whr_pkg::SEED_W-1:0] seed,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_bit,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_bit,
  output logic                       done
);
  import whr_pkg::*;

  localparam int N     = 1 << LOG2N;
  localparam int ACC_W = 2 * LOG2N + 2;
  localparam int PW    = $clog2(LOG2N + 1);
  localparam int PRW   = LOG2N - 1;
  localparam int MAG_W = LOG2N / 2;

  whr_state_e              state;
  logic [LOG2N-1:0]        cnt;
  logic [PW-1:0]           pass;
  logic [PRW-1:0]          pair;
  logic signed [ACC_W-1:0] mem [N];

  logic [LOG2N-1:0]        idx_lo, idx_hi;
  logic signed [ACC_W-1:0] bf_sum, bf_diff, cls_out, cur;
  logic                    pert_neg;
  logic [MAG_W-1:0]        pert_mag;
  logic                    bfly_on, last_pair, last_idx;

  assign cur       = mem[cnt];
  assign bfly_on   = (state == ST_FWD) || (state == ST_INV);
  assign last_pair = (pair == {PRW{1'b1}});
  assign last_idx  = (cnt == {LOG2N{1'b1}});

  whr_lfsr #(.MAG_W(MAG_W)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((state == ST_IDLE) && start),
    .seed     (seed),
    .advance  (state == ST_CLASS),
    .pert_neg (pert_neg),
    .pert_mag (pert_mag)
  );

  whr_butterfly #(.LOG2N(LOG2N), .ACC_W(ACC_W), .PW(PW)) u_bfly (
    .pass   (pass),
    .pair   (pair),
    .a      (mem[idx_lo]),
    .b      (mem[idx_hi]),
    .idx_lo (idx_lo),
    .idx_hi (idx_hi),
    .sum    (bf_sum),
    .diff   (bf_diff)
  );

  whr_classify #(.N(N), .ACC_W(ACC_W), .MAG_W(MAG_W)) u_cls (
    .coef     (cur),
    .pert_neg (pert_neg),
    .pert_mag (pert_mag),
    .coef_out (cls_out)
  );

  // sample store: bits, then spectrum, then regenerated samples
  always_ff @(posedge clk) begin
    if (state == ST_LOAD && in_valid)
      mem[cnt] <= in_bit ? ACC_W'(1) : -ACC_W'(1);
    else if (state == ST_CLASS)
      mem[cnt] <= cls_out;
    else if (bfly_on) begin
      mem[idx_lo] <= bf_sum;
      mem[idx_hi] <= bf_diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pass  <= '0;
      pair  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (last_idx) begin
            state <= ST_FWD;
            pass  <= '0;
            pair  <= '0;
          end
        end
        ST_FWD, ST_INV: begin
          pair <= pair + 1'b1;
          if (last_pair) begin
            if (pass == PW'(LOG2N - 1)) begin
              state <= (state == ST_FWD) ? ST_CLASS : ST_EMIT;
              cnt   <= '0;
              pass  <= '0;
            end else begin
              pass <= pass + 1'b1;
            end
          end
        end
        ST_CLASS: begin
          cnt <= cnt + 1'b1;
          if (last_idx) begin
            state <= ST_INV;
            pass  <= '0;
            pair  <= '0;
          end
        end
        ST_EMIT: if (out_ready) begin
          cnt <= cnt + 1'b1;
          if (last_idx) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_EMIT);
  assign out_bit   = ~cur[ACC_W-1];
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/whr_regen_chk.sv
module whr_regen_chk #(
  parameter int LOG2N = 7
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic done
);
  localparam int N = 1 << LOG2N;

  logic [LOG2N:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hs_cnt <= '0;
    else if (done)                   hs_cnt <= '0;
    else if (out_valid && out_ready) hs_cnt <= hs_cnt + 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hs_cnt == (LOG2N+1)'(N) && !out_valid);

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid && !done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start |=> !in_ready);
endmodule

bind walsh_regen whr_regen_chk #(.LOG2N(LOG2N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .done      (done)
);

// File: tb/test_walsh_regen.sv
module test_walsh_regen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] seed = 0;
  logic        in_valid = 0;
  logic        in_bit = 0;
  logic        out_ready = 1;
  logic        in_ready, out_valid, out_bit, done;

  int  n_checks = 0;
  int  n_fail = 0;
  int  stall_mode = 0;
  bit  exp_q[$];
  int unsigned rng = 32'h1357_9bdf;

  always #(CLK_PERIOD/2) clk = ~clk;

  walsh_regen i_walsh_regen (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit next_rnd_bit();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[16];
  endfunction

  // spectral model written from the requirements
  task automatic model(input bit b[N], input logic [15:0] sd,
                       output bit e[N], output int zeros);
    int c [N];
    int y, mag;
    logic [15:0] s;
    for (int k = 0; k < N; k++) begin
      c[k] = 0;
      for (int n = 0; n < N; n++)
        c[k] += (b[n] ? 1 : -1) * (($countones(k & n) % 2 == 1) ? -1 : 1);
    end
    s = (sd == 16'h0) ? 16'h1 : sd;
    for (int k = 0; k < N; k++) begin
      if (c[k] * c[k] <= N) begin
        mag  = int'(s[2:0]);
        c[k] = s[15] ? -mag : mag;
      end
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    end
    zeros = 0;
    for (int n = 0; n < N; n++) begin
      y = 0;
      for (int k = 0; k < N; k++)
        y += c[k] * (($countones(k & n) % 2 == 1) ? -1 : 1);
      if (y == 0) zeros++;
      e[n] = (y >= 0);
    end
  endtask

  // output ready driver
  initial begin
    int tick = 0;
    forever begin
      @(posedge clk); #1;
      tick++;
      out_ready = (stall_mode == 0) ? 1'b1 : ((tick % 3) != 0);
    end
  end

  // monitor: scoreboard pop and stall hold
  initial begin
    bit prev_stall = 0;
    bit prev_bit = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          // R8 hold under back-pressure
          check(out_valid == 1'b1 && out_bit == prev_bit, "R8", "held bit",
                int'(out_bit), int'(prev_bit));
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0)
            check(1'b0, "R8", "unexpected output bit", 1, 0);
          else begin
            bit e;
            e = exp_q.pop_front();
            // R2 R3 R4 R6 R7 stream content and order
            check(out_bit == e, "R2 R3 R4 R6", "regenerated bit", int'(out_bit), int'(e));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_bit   = out_bit;
      end
    end
  end

  task automatic run_case(input bit b[N], input logic [15:0] sd,
                          input int stalls, input bit gaps, input bit noise);
    bit e [N];
    int z;
    model(b, sd, e, z);
    for (int n = 0; n < N; n++) exp_q.push_back(e[n]);
    stall_mode = stalls;
    @(posedge clk); #1;
    start = 1; seed = sd;
    @(posedge clk); #1;
    start = 0; seed = ~sd;
    check(in_ready == 1'b1, "R1", "in_ready after start", int'(in_ready), 1);
    for (int n = 0; n < N; n++) begin
      if (gaps && (n % 5 == 2)) begin
        in_valid = 0;
        in_bit = ~b[n];
        @(posedge clk); #1;
      end
      in_valid = 1;
      in_bit = b[n];
      @(posedge clk); #1;
    end
    in_valid = noise;
    in_bit = 1;
    check(in_ready == 1'b0, "R1", "in_ready after N bits", int'(in_ready), 0);
    if (noise) begin
      // R10 start while transforming is ignored
      start = 1;
      @(posedge clk); #1;
      start = 0;
      in_bit = 0;
      @(posedge clk); #1;
      in_valid = 0;
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      @(posedge clk); #1;
      start = 1;
      @(posedge clk); #1;
      start = 0;
      check(in_ready == 1'b0, "R10", "start during emit", int'(in_ready), 0);
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, "R9", "bits left at done", exp_q.size(), 0);
    check(out_valid == 1'b0, "R9", "out_valid at done", int'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", int'(done), 0);
    check(in_ready == 1'b0, "R1", "in_ready idle", int'(in_ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    bit pat [N];
    bit e [N];
    int z;
    logic [15:0] zseed;
    bit found;

    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(in_ready == 1'b0, "R11", "in_ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    check(done == 1'b0, "R11", "done in reset", int'(done), 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(in_ready == 1'b0, "R11", "in_ready after reset", int'(in_ready), 0);

    // R1 input ignored while idle
    in_valid = 1; in_bit = 1;
    repeat (3) @(posedge clk); #1;
    in_valid = 0;
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1", "idle input", int'(out_valid), 0);

    // all ones: only coefficient 0 is strong
    for (int n = 0; n < N; n++) pat[n] = 1;
    run_case(pat, 16'h1234, 0, 0, 0);

    // all zeros with a zero seed (R5)
    for (int n = 0; n < N; n++) pat[n] = 0;
    run_case(pat, 16'h0000, 1, 0, 0);

    // alternating: Walsh row 1 (R2)
    for (int n = 0; n < N; n++) pat[n] = (n % 2 == 0);
    run_case(pat, 16'hACE1, 1, 1, 0);

    // row 2 pattern 1100 (R2)
    for (int n = 0; n < N; n++) pat[n] = ((n % 4) < 2);
    run_case(pat, 16'h00FF, 0, 1, 0);

    // pseudo-random stream, gaps, stalls, busy start (R10)
    for (int n = 0; n < N; n++) pat[n] = next_rnd_bit();
    run_case(pat, 16'hBEEF, 1, 1, 1);

    // R5 seed 0 and seed 1 must give the same stream
    run_case(pat, 16'h0000, 0, 0, 0);
    run_case(pat, 16'h0001, 0, 0, 0);

    // R7 search for a seed that makes a sample exactly zero
    for (int n = 0; n < N; n++) pat[n] = next_rnd_bit();
    found = 0;
    zseed = 16'h0;
    for (int s = 1; s < 400 && !found; s++) begin
      model(pat, 16'(s * 16'd2654 + 16'd77), e, z);
      if (z > 0) begin
        found = 1;
        zseed = 16'(s * 16'd2654 + 16'd77);
      end
    end
    check(found, "R7", "zero-sample seed found", int'(found), 1);
    if (found) run_case(pat, zseed, 1, 0, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule